// File: doc/BRIEF.md
# Recorder Command Decoder

This block sits behind a character link (typically a UART receiver) and turns short ASCII control lines into actions on a tape recorder's transport. It collects bytes into a line, recognises a small fixed vocabulary of motion, stop, load and rate-setting commands, and answers status queries with short ASCII replies. It holds the transport state and the selected aggregate bit rate as registered outputs, so the mechanics and the data path can follow them directly.

Every non-empty line produces exactly one reply on the response byte stream. The reply is either `OK`, `ER`, or a `XX=value` answer to a query, and it always ends with a line feed. Replies leave the block one byte per clock with no back-pressure. Load and unload commands are passed on to the mechanics as one-cycle pulses. Tape presence, readiness, end positions, data availability and remaining length arrive as plain level inputs and are reported on request.

Top module: `rcmd_decoder`

## Requirements
- R1: After reset the transport state is 0 (stopped), the rate code is 0 (64 Mbit/s), `tx_valid` is low, and both mechanics pulses are low.
- R2: A line ends with CR (0x0D) or LF (0x0A). A line with no characters produces no reply. Trailing spaces (0x20) are ignored. A line of more than `MAX_LEN` (16) characters before its terminator is answered `ER` and has no effect, while exactly 16 characters are parsed normally.
- R3: The motion commands `REC`, `PLAY`, `SYNR`, `SYNP`, `FF` and `RW` set the transport state to 1, 2, 3, 4, 5 and 6 respectively and are answered `OK`. Switching directly between motion states is allowed.
- R4: `STOP` is always accepted: it sets the state to 0 and replies `OK`.
- R5: A motion command is answered `ER` and leaves the state unchanged unless `tape_present` and `tape_ready` are both high.
- R6: `BR=nnnn` with nnnn exactly one of 0064, 0128, 0256, 0512, 1024, 2048 sets the rate code to 0 to 5 in that order and replies `OK`. Any other value leaves the rate unchanged and replies `ER`.
- R7: In state 5 the transport returns to state 0 on the clock edge that samples `at_eot` high. In state 6 it does the same on the edge that samples `at_bot` high.
- R8: `ST?` replies `ST=` followed by ID, RC, PL, SR, SP, FF or RW for states 0 to 6. `BR?` replies `BR=` followed by the current four-digit rate.
- R9: `TP?` replies NM (not present), RD (present and ready) or NR (present, not ready). `PS?` replies BT if `at_bot` is high, else ET if `at_eot` is high, else MD. `RM?` replies the remaining percentage as two decimal digits, saturated at 99. `DA?` replies YS or NO from `data_avail`.
- R10: The first reply byte is valid in the cycle after the edge that samples the terminator. The bytes follow on consecutive cycles and the last one is LF. Input bytes sampled while a reply is being sent are ignored.
- R11: `LOAD` and `UNLD` are accepted only in state 0. They give a one-cycle `load_pulse` or `unload_pulse` in the same cycle as the first reply byte. In any other state they are answered `ER`.
- R12: Unknown keywords, lowercase text, queries of unknown names and `BR=` with the wrong number of digits are answered `ER` and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | Strobe: `rx_data` holds a new character this cycle |
| tape_present | input | 1 | A tape is mounted |
| tape_ready | input | 1 | Mounted tape is ready to move |
| at_bot | input | 1 | Tape is at its beginning |
| at_eot | input | 1 | Tape is at its end |
| data_avail | input | 1 | Playback data is available |
| tape_left_pct | input | 7 | Tape remaining, percent |
| xport_state | output | 3 | Transport state code (0 to 6) |
| rate_code | output | 3 | Selected rate code (0 to 5) |
| load_pulse | output | 1 | One-cycle request to load a tape |
| unload_pulse | output | 1 | One-cycle request to unload a tape |
| tx_data | output | 8 | Reply character |
| tx_valid | output | 1 | `tx_data` holds a reply character this cycle |

## Verification
The bench builds the decoder with the default line limit of 16 characters. With that limit, a rate command padded with trailing spaces can land exactly on the limit and one character past it, so the accept/reject boundary is checked with an observable rate change. The behavioural model tracks transport state and rate on every clock, including the end-of-tape and beginning-of-tape fallbacks. Each reply is compared as a whole string, together with the cycle in which it starts and whether its bytes are contiguous. Noise bytes are injected while a reply is being sent, which exercises the rule that input is ignored while a reply is in flight.

// File: rtl/rcmd_pkg.sv
package rcmd_pkg;

    typedef enum logic [2:0] {
        XP_IDLE  = 3'd0,
        XP_REC   = 3'd1,
        XP_PLAY  = 3'd2,
        XP_SREC  = 3'd3,
        XP_SPLAY = 3'd4,
        XP_FWD   = 3'd5,
        XP_REW   = 3'd6
    } xport_e;

    typedef enum logic [2:0] {
        C_BAD, C_MOVE, C_STOP, C_LOAD, C_UNLD, C_RATE, C_QUERY
    } cmd_e;

    localparam int REPLY_BYTES = 8;
    localparam int REPLY_LW    = $clog2(REPLY_BYTES + 1);
    typedef logic [REPLY_BYTES-1:0][7:0] reply_t;

    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_SP = 8'h20;

    // Four-digit text of a rate code.
    function automatic logic [31:0] rate_text(input logic [2:0] code);
        case (code)
            3'd0:    return "0064";
            3'd1:    return "0128";
            3'd2:    return "0256";
            3'd3:    return "0512";
            3'd4:    return "1024";
            default: return "2048";
        endcase
    endfunction

    // Two-letter name of a transport state.
    function automatic logic [15:0] xport_text(input logic [2:0] st);
        case (st)
            3'd1:    return "RC";
            3'd2:    return "PL";
            3'd3:    return "SR";
            3'd4:    return "SP";
            3'd5:    return "FF";
            3'd6:    return "RW";
            default: return "ID";
        endcase
    endfunction

    // Two decimal digits of a percentage, saturated at 99.
    function automatic logic [15:0] pct_text(input logic [6:0] pct);
        logic [6:0] sat;
        logic [6:0] tens;
        logic [6:0] ones;
        sat  = (pct > 7'd99) ? 7'd99 : pct;
        tens = sat / 7'd10;
        ones = sat - tens * 7'd10;
        return {8'h30 + {1'b0, tens}, 8'h30 + {1'b0, ones}};
    endfunction

endpackage

// File: rtl/rcmd_linebuf.sv
module rcmd_linebuf #(
    parameter int MAX_LEN = 16,
    parameter int LW      = $clog2(MAX_LEN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                rx_data,
    input  logic                      rx_valid,
    input  logic                      hold,
    output logic                      line_end,
    output logic [MAX_LEN-1:0][7:0]   line_chars,
    output logic [LW-1:0]             line_len,
    output logic                      line_ovf
);
    import rcmd_pkg::*;

    typedef struct packed {
        logic [MAX_LEN-1:0][7:0] chars;
        logic [LW-1:0]           len;
        logic                    ovf;
    } lb_t;

    lb_t  q, d;
    logic accept;
    logic is_term;

    always_comb begin
        d        = q;
        line_end = 1'b0;
        accept   = rx_valid && !hold;
        is_term  = (rx_data == CH_CR) || (rx_data == CH_LF);
        if (accept) begin
            if (is_term) begin
                line_end = 1'b1;
                d.len    = '0;
                d.ovf    = 1'b0;
            end else if (q.len == LW'(MAX_LEN)) begin
                d.ovf = 1'b1;
            end else begin
                for (int i = 0; i < MAX_LEN; i++) begin
                    if (q.len == LW'(i)) d.chars[i] = rx_data;
                end
                d.len = q.len + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_chars = q.chars;
    assign line_len   = q.len;
    assign line_ovf   = q.ovf;

    // R2: the stored length never passes the line limit
    a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.len <= LW'(MAX_LEN));

    // R10: characters offered while a reply is in flight leave the buffer alone
    a_r10_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && rx_valid) |=> ($stable(q.len) && $stable(q.ovf)));

endmodule

// File: rtl/rcmd_exec.sv
module rcmd_exec #(
    parameter int MAX_LEN = 16,
    parameter int LW      = $clog2(MAX_LEN + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              line_end,
    input  logic [MAX_LEN-1:0][7:0]           line_chars,
    input  logic [LW-1:0]                     line_len,
    input  logic                              line_ovf,
    input  logic                              tape_present,
    input  logic                              tape_ready,
    input  logic                              at_bot,
    input  logic                              at_eot,
    input  logic                              data_avail,
    input  logic [6:0]                        tape_left_pct,
    output logic [2:0]                        xport_state,
    output logic [2:0]                        rate_code,
    output logic                              load_pulse,
    output logic                              unload_pulse,
    output logic                              reply_go,
    output rcmd_pkg::reply_t                  reply,
    output logic [rcmd_pkg::REPLY_LW-1:0]     reply_len
);
    import rcmd_pkg::*;

    typedef struct packed {
        xport_e     xport;
        logic [2:0] rate;
        logic       load;
        logic       unload;
    } ex_t;

    ex_t         q, d;
    logic [LW-1:0] eff;
    logic [15:0] w2;
    logic [23:0] w3;
    logic [31:0] w4;
    logic [31:0] wnum;
    cmd_e        cmd;
    xport_e      tgt;
    logic [2:0]  new_rate;
    logic        said_ok;
    logic [15:0] qname;
    logic [31:0] qval;
    logic        qwide;
    logic        mech_ok;

    assign w2   = {line_chars[0], line_chars[1]};
    assign w3   = {line_chars[0], line_chars[1], line_chars[2]};
    assign w4   = {line_chars[0], line_chars[1], line_chars[2], line_chars[3]};
    assign wnum = {line_chars[3], line_chars[4], line_chars[5], line_chars[6]};
    assign mech_ok = tape_present && tape_ready;

    // Length without trailing spaces
    always_comb begin
        eff = '0;
        for (int i = 0; i < MAX_LEN; i++) begin
            if ((LW'(i) < line_len) && (line_chars[i] != CH_SP)) eff = LW'(i + 1);
        end
    end

    // Keyword and field recognition
    always_comb begin
        cmd      = C_BAD;
        tgt      = XP_IDLE;
        new_rate = q.rate;
        qname    = '0;
        qval     = '0;
        qwide    = 1'b0;
        if (eff == LW'(3) && w3 == "REC") begin
            cmd = C_MOVE; tgt = XP_REC;
        end else if (eff == LW'(4) && w4 == "PLAY") begin
            cmd = C_MOVE; tgt = XP_PLAY;
        end else if (eff == LW'(4) && w4 == "SYNR") begin
            cmd = C_MOVE; tgt = XP_SREC;
        end else if (eff == LW'(4) && w4 == "SYNP") begin
            cmd = C_MOVE; tgt = XP_SPLAY;
        end else if (eff == LW'(2) && w2 == "FF") begin
            cmd = C_MOVE; tgt = XP_FWD;
        end else if (eff == LW'(2) && w2 == "RW") begin
            cmd = C_MOVE; tgt = XP_REW;
        end else if (eff == LW'(4) && w4 == "STOP") begin
            cmd = C_STOP;
        end else if (eff == LW'(4) && w4 == "LOAD") begin
            cmd = C_LOAD;
        end else if (eff == LW'(4) && w4 == "UNLD") begin
            cmd = C_UNLD;
        end else if (eff == LW'(7) && w3 == "BR=") begin
            cmd = C_RATE;
            case (wnum)
                "0064":  new_rate = 3'd0;
                "0128":  new_rate = 3'd1;
                "0256":  new_rate = 3'd2;
                "0512":  new_rate = 3'd3;
                "1024":  new_rate = 3'd4;
                "2048":  new_rate = 3'd5;
                default: cmd = C_BAD;
            endcase
        end else if (eff == LW'(3) && line_chars[2] == "?") begin
            cmd   = C_QUERY;
            qname = w2;
            case (w2)
                "BR": begin qval = rate_text(q.rate); qwide = 1'b1; end
                "ST": qval[15:0] = xport_text(q.xport);
                "TP": qval[15:0] = !tape_present ? "NM" : (tape_ready ? "RD" : "NR");
                "PS": qval[15:0] = at_bot ? "BT" : (at_eot ? "ET" : "MD");
                "RM": qval[15:0] = pct_text(tape_left_pct);
                "DA": qval[15:0] = data_avail ? "YS" : "NO";
                default: cmd = C_BAD;
            endcase
        end
    end

    // Next state and reply
    always_comb begin
        d        = q;
        d.load   = 1'b0;
        d.unload = 1'b0;
        reply    = '0;
        reply_len = '0;
        reply_go = 1'b0;
        said_ok  = 1'b0;

        if (q.xport == XP_FWD && at_eot) d.xport = XP_IDLE;
        if (q.xport == XP_REW && at_bot) d.xport = XP_IDLE;

        if (line_end && (line_ovf || eff != '0)) begin
            reply_go = 1'b1;
            if (!line_ovf) begin
                case (cmd)
                    C_MOVE: if (mech_ok) begin
                        d.xport = tgt; said_ok = 1'b1;
                    end
                    C_STOP: begin
                        d.xport = XP_IDLE; said_ok = 1'b1;
                    end
                    C_LOAD: if (q.xport == XP_IDLE) begin
                        d.load = 1'b1; said_ok = 1'b1;
                    end
                    C_UNLD: if (q.xport == XP_IDLE) begin
                        d.unload = 1'b1; said_ok = 1'b1;
                    end
                    C_RATE: begin
                        d.rate = new_rate; said_ok = 1'b1;
                    end
                    default: ;
                endcase
            end
            if (!line_ovf && cmd == C_QUERY) begin
                reply[0] = qname[15:8];
                reply[1] = qname[7:0];
                reply[2] = "=";
                if (qwide) begin
                    reply[3] = qval[31:24];
                    reply[4] = qval[23:16];
                    reply[5] = qval[15:8];
                    reply[6] = qval[7:0];
                    reply[7] = CH_LF;
                    reply_len = REPLY_LW'(8);
                end else begin
                    reply[3] = qval[15:8];
                    reply[4] = qval[7:0];
                    reply[5] = CH_LF;
                    reply_len = REPLY_LW'(6);
                end
            end else begin
                reply[0] = said_ok ? "O" : "E";
                reply[1] = said_ok ? "K" : "R";
                reply[2] = CH_LF;
                reply_len = REPLY_LW'(3);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.xport  <= XP_IDLE;
            q.rate   <= 3'd0;
            q.load   <= 1'b0;
            q.unload <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign xport_state  = q.xport;
    assign rate_code    = q.rate;
    assign load_pulse   = q.load;
    assign unload_pulse = q.unload;

    // R5: without a ready tape a line can only keep the state or stop it
    a_r5_motion_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !(tape_present && tape_ready))
        |=> ($stable(q.xport) || q.xport == XP_IDLE));

    // R7: fast forward halts at the tape end unless a line overrides it
    a_r7_fwd_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (q.xport == XP_FWD && at_eot && !line_end) |=> (q.xport == XP_IDLE));

    // R7: rewind halts at the tape head unless a line overrides it
    a_r7_rew_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (q.xport == XP_REW && at_bot && !line_end) |=> (q.xport == XP_IDLE));

    // R6: the rate moves only as the result of a completed line
    a_r6_rate_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(q.rate));

    // R11: a mechanics pulse follows a line taken in the stopped state
    a_r11_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (q.load || q.unload) |-> ($past(line_end) && $past(q.xport) == XP_IDLE));

endmodule

// File: rtl/rcmd_txfmt.sv
module rcmd_txfmt (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  rcmd_pkg::reply_t                  reply,
    input  logic [rcmd_pkg::REPLY_LW-1:0]     reply_len,
    output logic                              busy,
    output logic [7:0]                        tx_data,
    output logic                              tx_valid
);
    import rcmd_pkg::*;

    localparam int IW = $clog2(REPLY_BYTES);

    typedef struct packed {
        reply_t              bytes;
        logic [REPLY_LW-1:0] cnt;
        logic [IW-1:0]       idx;
    } tf_t;

    tf_t q, d;

    always_comb begin
        d = q;
        if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
            d.idx = q.idx + 1'b1;
        end
        if (load) begin
            d.bytes = reply;
            d.cnt   = reply_len;
            d.idx   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_valid = (q.cnt != '0);
    assign busy     = tx_valid;
    assign tx_data  = q.bytes[q.idx];

    // R10: a new reply never starts on top of one in flight
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);

    // R10: the final byte of every reply is a line feed
    a_r10_ends_lf: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && q.cnt == REPLY_LW'(1)) |-> (tx_data == CH_LF));

endmodule

// File: rtl/rcmd_decoder.sv
module rcmd_decoder #(
    parameter int MAX_LEN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    input  logic       tape_present,
    input  logic       tape_ready,
    input  logic       at_bot,
    input  logic       at_eot,
    input  logic       data_avail,
    input  logic [6:0] tape_left_pct,
    output logic [2:0] xport_state,
    output logic [2:0] rate_code,
    output logic       load_pulse,
    output logic       unload_pulse,
    output logic [7:0] tx_data,
    output logic       tx_valid
);
    import rcmd_pkg::*;

    localparam int LW = $clog2(MAX_LEN + 1);

    logic                    busy;
    logic                    line_end;
    logic [MAX_LEN-1:0][7:0] line_chars;
    logic [LW-1:0]           line_len;
    logic                    line_ovf;
    logic                    reply_go;
    reply_t                  reply;
    logic [REPLY_LW-1:0]     reply_len;

    rcmd_linebuf #(.MAX_LEN(MAX_LEN), .LW(LW)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .hold       (busy),
        .line_end   (line_end),
        .line_chars (line_chars),
        .line_len   (line_len),
        .line_ovf   (line_ovf)
    );

    rcmd_exec #(.MAX_LEN(MAX_LEN), .LW(LW)) u_exec (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_end      (line_end),
        .line_chars    (line_chars),
        .line_len      (line_len),
        .line_ovf      (line_ovf),
        .tape_present  (tape_present),
        .tape_ready    (tape_ready),
        .at_bot        (at_bot),
        .at_eot        (at_eot),
        .data_avail    (data_avail),
        .tape_left_pct (tape_left_pct),
        .xport_state   (xport_state),
        .rate_code     (rate_code),
        .load_pulse    (load_pulse),
        .unload_pulse  (unload_pulse),
        .reply_go      (reply_go),
        .reply         (reply),
        .reply_len     (reply_len)
    );

    rcmd_txfmt u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (reply_go),
        .reply     (reply),
        .reply_len (reply_len),
        .busy      (busy),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid)
    );

endmodule

// File: tb/tb_rcmd_decoder.sv
module tb_rcmd_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0;
    logic       tp = 1'b0, tr = 1'b0, bot = 1'b0, eot = 1'b0, da = 1'b0;
    logic [6:0] pct = 7'd0;
    logic [2:0] xport_state, rate_code;
    logic       load_pulse, unload_pulse;
    logic [7:0] tx_data;
    logic       tx_valid;

    int checks = 0;
    int errors = 0;
    bit ready_cmp = 1'b0;
    bit done = 1'b0;

    int mstate = 0;
    int mrate  = 0;
    int rates[6] = '{64, 128, 256, 512, 1024, 2048};
    string snames[7] = '{"ID", "RC", "PL", "SR", "SP", "FF", "RW"};

    always #2 clk = ~clk;

    rcmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .tape_present(tp), .tape_ready(tr), .at_bot(bot), .at_eot(eot),
        .data_avail(da), .tape_left_pct(pct),
        .xport_state(xport_state), .rate_code(rate_code),
        .load_pulse(load_pulse), .unload_pulse(unload_pulse),
        .tx_data(tx_data), .tx_valid(tx_valid)
    );

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    // Model fallback of R7, evaluated at each edge
    always @(posedge clk) begin
        if (rst_n) begin
            if (mstate == 5 && eot) mstate = 0;
            if (mstate == 6 && bot) mstate = 0;
        end
    end

    // Per-cycle comparison of state and rate against the model (R3 R4 R6 R7)
    always @(negedge clk) begin
        if (ready_cmp && !done) begin
            check(xport_state == 3'(mstate) && rate_code == 3'(mrate), "R3/R6 state",
                  $sformatf("state %0d rate %0d, expected state %0d rate %0d",
                            xport_state, rate_code, mstate, mrate));
        end
    end

    // Behavioural model of one line; returns the expected reply text
    function automatic string model_line(input string raw, output bit ld, output bit ul);
        string t;
        int    tgt;
        ld = 1'b0;
        ul = 1'b0;
        if (raw.len() > 16) return "ER\n";
        t = raw;
        while (t.len() > 0 && t[t.len()-1] == " ") t = t.substr(0, t.len() - 2);
        if (t.len() == 0) return "";
        tgt = -1;
        if (t == "REC") tgt = 1;
        else if (t == "PLAY") tgt = 2;
        else if (t == "SYNR") tgt = 3;
        else if (t == "SYNP") tgt = 4;
        else if (t == "FF") tgt = 5;
        else if (t == "RW") tgt = 6;
        if (tgt >= 0) begin
            if (tp && tr) begin mstate = tgt; return "OK\n"; end
            return "ER\n";
        end
        if (t == "STOP") begin mstate = 0; return "OK\n"; end
        if (t == "LOAD" || t == "UNLD") begin
            if (mstate != 0) return "ER\n";
            if (t == "LOAD") ld = 1'b1; else ul = 1'b1;
            return "OK\n";
        end
        if (t.len() == 7 && t.substr(0, 2) == "BR=") begin
            for (int k = 0; k < 6; k++) begin
                if (t.substr(3, 6) == $sformatf("%04d", rates[k])) begin
                    mrate = k;
                    return "OK\n";
                end
            end
            return "ER\n";
        end
        if (t.len() == 3 && t[2] == "?") begin
            string nm;
            nm = t.substr(0, 1);
            if (nm == "BR") return $sformatf("BR=%04d\n", rates[mrate]);
            if (nm == "ST") return {"ST=", snames[mstate], "\n"};
            if (nm == "TP") return !tp ? "TP=NM\n" : (tr ? "TP=RD\n" : "TP=NR\n");
            if (nm == "PS") return bot ? "PS=BT\n" : (eot ? "PS=ET\n" : "PS=MD\n");
            if (nm == "RM") return $sformatf("RM=%02d\n", (pct > 99) ? 99 : pct);
            if (nm == "DA") return da ? "DA=YS\n" : "DA=NO\n";
        end
        return "ER\n";
    endfunction

    // Send one line, then collect and compare the reply (R10 timing included).
    // noise bytes are offered during the reply and must be ignored.
    task automatic send_line(input string raw, input byte term, input string noise,
                             input string req);
        string exp_s, got;
        bit    eld, eul;
        bit    seen_lf;
        for (int i = 0; i < raw.len(); i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = raw[i];
        end
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = term;
        @(posedge clk);
        exp_s = model_line(raw, eld, eul);
        got = "";
        seen_lf = 1'b0;
        for (int k = 0; k < 12 && !seen_lf; k++) begin
            @(negedge clk);
            if (k < noise.len()) begin
                rx_valid = 1'b1;
                rx_data  = noise[k];
            end else begin
                rx_valid = 1'b0;
            end
            if (k == 0) begin
                check(load_pulse == eld && unload_pulse == eul, "R11",
                      $sformatf("'%s' pulses %0d/%0d, expected %0d/%0d",
                                raw, load_pulse, unload_pulse, eld, eul));
            end
            if (exp_s.len() == 0) begin
                if (k >= 3) break;
                check(!tx_valid, "R2", $sformatf("empty line gave tx_valid=%0d, expected 0", tx_valid));
            end else if (!tx_valid) begin
                break;
            end else begin
                got = $sformatf("%s%c", got, tx_data);
                if (tx_data == 8'h0A) seen_lf = 1'b1;
            end
        end
        if (exp_s.len() != 0) begin
            check(got == exp_s, req,
                  $sformatf("line '%s' reply '%s', expected '%s'", raw, got, exp_s));
            @(negedge clk);
            rx_valid = 1'b0;
            check(!tx_valid, "R10", $sformatf("tx_valid=%0d after LF, expected 0", tx_valid));
        end
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check(xport_state == 3'd0 && rate_code == 3'd0, "R1",
              $sformatf("state %0d rate %0d, expected 0 0", xport_state, rate_code));
        check(!tx_valid && !load_pulse && !unload_pulse, "R1",
              $sformatf("tx_valid %0d pulses %0d%0d, expected 0 00", tx_valid, load_pulse, unload_pulse));
        ready_cmp = 1'b1;

        // R5 / R9: no tape
        send_line("REC", 8'h0A, "", "R5");
        send_line("TP?", 8'h0A, "", "R9");
        tp = 1'b1;
        send_line("PLAY", 8'h0A, "", "R5");
        send_line("TP?", 8'h0A, "", "R9");
        tr = 1'b1;
        send_line("TP?", 8'h0A, "", "R9");

        // R3 / R8 motion and state query
        send_line("REC", 8'h0A, "", "R3");
        send_line("ST?", 8'h0A, "", "R8");
        send_line("PLAY", 8'h0A, "", "R3");
        send_line("SYNR", 8'h0A, "", "R3");
        send_line("ST?", 8'h0A, "", "R8");
        send_line("SYNP", 8'h0A, "", "R3");
        send_line("LOAD", 8'h0A, "", "R11");
        send_line("STOP", 8'h0A, "", "R4");
        send_line("STOP", 8'h0A, "", "R4");
        send_line("LOAD", 8'h0A, "", "R11");
        send_line("UNLD", 8'h0A, "", "R11");

        // R6 rate selection
        send_line("BR?", 8'h0A, "", "R8");
        send_line("BR=1024", 8'h0A, "", "R6");
        send_line("BR?", 8'h0A, "", "R8");
        send_line("BR=0100", 8'h0A, "", "R6");
        send_line("BR=2048", 8'h0A, "", "R6");
        send_line("BR=064", 8'h0A, "", "R12");
        send_line("BR=0512    ", 8'h0A, "", "R2");
        send_line("BR=0256         ", 8'h0A, "", "R2");
        send_line("BR=0128          ", 8'h0A, "", "R2");
        send_line("BR?", 8'h0A, "", "R2");
        send_line("BR=0128", 8'h0D, "", "R2");

        // R12 malformed input
        send_line("rec", 8'h0A, "", "R12");
        send_line("XY?", 8'h0A, "", "R12");
        send_line("FOO", 8'h0A, "", "R12");
        send_line("", 8'h0A, "", "R2");

        // R7 fallbacks
        send_line("FF", 8'h0A, "", "R3");
        repeat (3) @(negedge clk);
        eot = 1'b1;
        repeat (3) @(negedge clk);
        send_line("ST?", 8'h0A, "", "R7");
        send_line("PS?", 8'h0A, "", "R9");
        bot = 1'b1;
        send_line("PS?", 8'h0A, "", "R9");
        bot = 1'b0;
        eot = 1'b0;
        send_line("PS?", 8'h0A, "", "R9");
        send_line("RW", 8'h0A, "", "R3");
        repeat (2) @(negedge clk);
        bot = 1'b1;
        repeat (2) @(negedge clk);
        send_line("ST?", 8'h0A, "", "R7");
        bot = 1'b0;

        // R9 remaining and data status
        pct = 7'd57;  send_line("RM?", 8'h0A, "", "R9");
        pct = 7'd100; send_line("RM?", 8'h0A, "", "R9");
        pct = 7'd5;   send_line("RM?", 8'h0A, "", "R9");
        da = 1'b1;    send_line("DA?", 8'h0A, "", "R9");
        da = 1'b0;    send_line("DA?", 8'h0A, "", "R9");

        // R10 input during a reply is ignored
        send_line("REC", 8'h0A, "", "R3");
        send_line("ST?", 8'h0D, "STOP\n", "R10");
        send_line("ST?", 8'h0A, "", "R10");
        send_line("STOP", 8'h0D, "\n", "R10");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule